// File: doc/BRIEF.md
# Cipher Key Slot Allocator

This block hands out key slot numbers to users of a cipher engine and takes them back when they are no longer needed. It keeps the free slots in a first-in first-out queue. An allocate request takes the slot at the head of the queue. A release request appends the slot to the tail. One slot index holds a secret loaded at boot, so it is never placed in the queue, never granted, and a release that names it is dropped without any effect.

The response to an allocation is registered. One cycle after the request edge, either a grant pulse carries the slot number, or a fail pulse reports that the pool was empty. A release of a slot that is already free is dropped and raises a sticky error flag, which stays set until reset.

The response path is a three-state machine with the states RSP_IDLE, RSP_GRANT and RSP_DENY. From any state, a sampled allocate request moves it to RSP_GRANT when the queue holds a slot, and to RSP_DENY when the queue is empty. With no request the machine returns to RSP_IDLE. So each response state lasts one cycle unless another request follows. The grant and fail outputs decode the state.

Top module: `keyslot_pool`

## Requirements
- R1: After reset the free queue holds every slot except the reserved one in ascending order. With the defaults, seven allocations return 0, 1, 2, 3, 5, 6 and 7, coded as unsigned binary on `grant_slot`.
- R2: The reserved slot (default 4) is never granted.
- R3: An allocate request sampled at a clock edge with a non-empty pool raises `grant_vld` for one cycle after that edge, with the head slot on `grant_slot` and `grant_fail` low. With no request, both pulses stay low.
- R4: An allocate request sampled while the pool is empty raises `grant_fail` for one cycle after that edge, with `grant_vld` low.
- R5: An accepted release appends the slot to the tail of the queue, so freed slots come back in the order they were released.
- R6: A release naming the reserved slot changes neither the pool nor `dup_err`.
- R7: A release naming a slot that is already free leaves the pool unchanged and sets `dup_err`, which stays high until reset.
- R8: An allocate and a release in the same cycle on an empty pool give a fail response, and the released slot is then queued and granted by the next allocation.
- R9: An allocate and a release in the same cycle on a non-empty pool grant the old head, and the released slot joins behind the slots already queued.
- R10: During and right after reset, `grant_vld`, `grant_fail` and `dup_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| alloc_req | input | 1 | Request one slot in this cycle |
| rel_req | input | 1 | Return `rel_slot` in this cycle |
| rel_slot | input | $clog2(NUM_SLOTS) | Slot number being returned |
| grant_vld | output | 1 | One-cycle pulse: a slot was granted |
| grant_slot | output | $clog2(NUM_SLOTS) | Granted slot number, valid with `grant_vld` |
| grant_fail | output | 1 | One-cycle pulse: allocation found the pool empty |
| dup_err | output | 1 | Sticky flag: a free slot was released again |

## Verification
A grant or a fail is due in the cycle that follows the edge that samples the allocate request. A release affects `dup_err` and the queue from the edge that samples it onward. The driver applies each stimulus on a falling edge, and before the next rising edge it pushes the response a reference pool model predicts. The monitor samples one nanosecond after every rising edge and compares the response due at that edge, or expects silence when none is queued. Reuse order is checked through later grants, and the sticky flag is compared on every cycle.

// File: rtl/kslot_pkg.sv
package kslot_pkg;

    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_GRANT = 2'd1,
        RSP_DENY  = 2'd2
    } rsp_state_e;

    // Slot stored at queue position idx after reset: skip the reserved index.
    function automatic int unsigned boot_slot(input int unsigned idx,
                                              input int unsigned resv);
        return (idx < resv) ? idx : idx + 1;
    endfunction

endpackage

// File: rtl/kslot_freeq.sv
module kslot_freeq #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SW = $clog2(NUM_SLOTS),
    localparam int unsigned CW = $clog2(NUM_SLOTS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [SW-1:0] push_slot,
    input  logic          pop,
    output logic [SW-1:0] head,
    output logic          empty
);
    import kslot_pkg::*;

    logic [SW-1:0] mem [NUM_SLOTS];
    logic [SW-1:0] rd_ptr, wr_ptr;
    logic [CW-1:0] count;

    function automatic logic [SW-1:0] step_ptr(input logic [SW-1:0] p);
        return (p == SW'(NUM_SLOTS - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++) begin
                if (i < NUM_SLOTS - 1)
                    mem[i] <= SW'(boot_slot(i, RESV_SLOT));
                else
                    mem[i] <= '0;
            end
        end else if (push) begin
            mem[wr_ptr] <= push_slot;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr <= '0;
            wr_ptr <= SW'(NUM_SLOTS - 1);
            count  <= CW'(NUM_SLOTS - 1);
        end else begin
            if (pop)  rd_ptr <= step_ptr(rd_ptr);
            if (push) wr_ptr <= step_ptr(wr_ptr);
            unique case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign head  = mem[rd_ptr];
    assign empty = (count == '0);

    // The pool never holds more than the non-reserved slots.
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |-> (count < CW'(NUM_SLOTS - 1)));

    p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (count != '0));

endmodule

// File: rtl/kslot_relchk.sv
module kslot_relchk #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
    input  logic                 rel_req,
    input  logic [SW-1:0]        rel_slot,
    input  logic [NUM_SLOTS-1:0] free_map,
    output logic                 accept,
    output logic                 dup
);
    logic in_range;
    logic is_resv;
    logic is_free;

    always_comb begin
        in_range = (int'(rel_slot) < NUM_SLOTS);
        is_resv  = (rel_slot == SW'(RESV_SLOT));
        is_free  = in_range && free_map[rel_slot];
        accept   = rel_req && in_range && !is_resv && !is_free;
        dup      = rel_req && !is_resv && is_free;
    end

endmodule

// File: rtl/keyslot_pool.sv
module keyslot_pool #(
    parameter int unsigned NUM_SLOTS = 8,
    parameter int unsigned RESV_SLOT = 4,
    localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          alloc_req,
    input  logic          rel_req,
    input  logic [SW-1:0] rel_slot,
    output logic          grant_vld,
    output logic [SW-1:0] grant_slot,
    output logic          grant_fail,
    output logic          dup_err
);
    import kslot_pkg::*;

    rsp_state_e           state_q, state_d;
    logic [SW-1:0]        head;
    logic                 q_empty;
    logic                 pop;
    logic                 rel_ok;
    logic                 rel_dup;
    logic [NUM_SLOTS-1:0] free_map;
    logic [SW-1:0]        slot_q;
    logic                 dup_q;

    assign pop = alloc_req && !q_empty;

    kslot_freeq #(.NUM_SLOTS(NUM_SLOTS), .RESV_SLOT(RESV_SLOT)) u_freeq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (rel_ok),
        .push_slot (rel_slot),
        .pop       (pop),
        .head      (head),
        .empty     (q_empty)
    );

    kslot_relchk #(.NUM_SLOTS(NUM_SLOTS), .RESV_SLOT(RESV_SLOT)) u_relchk (
        .rel_req  (rel_req),
        .rel_slot (rel_slot),
        .free_map (free_map),
        .accept   (rel_ok),
        .dup      (rel_dup)
    );

    // Membership map: which slots currently sit in the queue.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SLOTS; i++)
                free_map[i] <= (i != RESV_SLOT);
        end else begin
            if (pop)    free_map[head]     <= 1'b0;
            if (rel_ok) free_map[rel_slot] <= 1'b1;
        end
    end

    // Next-state logic of the response machine.
    always_comb begin
        state_d = RSP_IDLE;
        unique case (state_q)
            RSP_IDLE, RSP_GRANT, RSP_DENY: begin
                if (alloc_req)
                    state_d = q_empty ? RSP_DENY : RSP_GRANT;
                else
                    state_d = RSP_IDLE;
            end
            default: state_d = RSP_IDLE;
        endcase
    end

    // State register, granted-slot capture and sticky error.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RSP_IDLE;
            slot_q  <= '0;
            dup_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (pop)     slot_q <= head;
            if (rel_dup) dup_q  <= 1'b1;
        end
    end

    // Output decode.
    always_comb begin
        grant_vld  = (state_q == RSP_GRANT);
        grant_fail = (state_q == RSP_DENY);
        grant_slot = slot_q;
        dup_err    = dup_q;
    end

    p_vld_fail_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_vld && grant_fail));

    p_rsp_needs_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_vld || grant_fail) |-> $past(alloc_req));

    p_never_resv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        grant_vld |-> (grant_slot != SW'(RESV_SLOT)));

    p_resv_not_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !free_map[RESV_SLOT]);

    p_fail_on_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_req && q_empty) |=> grant_fail);

    p_dup_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        dup_err |=> dup_err);

    p_resv_release_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && rel_slot == SW'(RESV_SLOT)) |=> (dup_err == $past(dup_err)));

endmodule

// File: tb/sim_keyslot_pool.sv
`timescale 1ns/100ps
module sim_keyslot_pool;

    localparam int NS   = 8;
    localparam int RESV = 4;

    typedef struct {
        logic       fail;
        logic [2:0] slot;
        string      tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       alloc_req = 1'b0;
    logic       rel_req = 1'b0;
    logic [2:0] rel_slot = '0;
    logic       grant_vld;
    logic [2:0] grant_slot;
    logic       grant_fail;
    logic       dup_err;

    int   n_checks = 0;
    int   n_fails  = 0;
    bit   running  = 0;
    bit   finished = 0;

    exp_t expq[$];
    int   pool[$];
    bit   mfree[NS];
    bit   mdup = 0;

    always #2.5 clk = ~clk;

    keyslot_pool #(.NUM_SLOTS(NS), .RESV_SLOT(RESV)) u0 (
        .clk(clk), .rst_n(rst_n), .alloc_req(alloc_req), .rel_req(rel_req),
        .rel_slot(rel_slot), .grant_vld(grant_vld), .grant_slot(grant_slot),
        .grant_fail(grant_fail), .dup_err(dup_err)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%s expected=%s at %0t", tag, act, exp, $time);
        end
    endtask

    // Driver: apply one cycle of stimulus and predict its response.
    task automatic step(input bit a, input bit r, input int s, input string tag);
        bit dupnow;
        exp_t e;
        @(negedge clk);
        alloc_req = a;
        rel_req   = r;
        rel_slot  = 3'(s);
        dupnow = r && (s != RESV) && mfree[s];
        if (a) begin
            e.tag = tag;
            if (pool.size() == 0) begin
                e.fail = 1'b1; e.slot = '0;
            end else begin
                int h;
                h = pool.pop_front();
                mfree[h] = 0;
                e.fail = 1'b0; e.slot = 3'(h);
            end
            expq.push_back(e);
        end
        if (r && s != RESV) begin
            if (dupnow) mdup = 1;
            else begin pool.push_back(s); mfree[s] = 1; end
        end
    endtask

    // Monitor: compare the response due at each rising edge.
    initial begin
        wait (running);
        forever begin
            @(posedge clk);
            #1;
            if (expq.size() > 0) begin
                exp_t e;
                e = expq.pop_front();
                if (e.fail)
                    check(grant_fail && !grant_vld, e.tag,
                          $sformatf("vld=%0b fail=%0b", grant_vld, grant_fail), "vld=0 fail=1");
                else
                    check(grant_vld && !grant_fail && grant_slot == e.slot, e.tag,
                          $sformatf("vld=%0b fail=%0b slot=%0d", grant_vld, grant_fail, grant_slot),
                          $sformatf("vld=1 fail=0 slot=%0d", e.slot));
            end else begin
                check(!grant_vld && !grant_fail, "R3 idle",
                      $sformatf("vld=%0b fail=%0b", grant_vld, grant_fail), "vld=0 fail=0");
            end
            check(dup_err == mdup, "R7 dup_err",
                  $sformatf("%0b", dup_err), $sformatf("%0b", mdup));
        end
    end

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] lfsr;
        for (int i = 0; i < NS; i++) mfree[i] = (i != RESV);
        for (int i = 0; i < NS; i++) if (i != RESV) pool.push_back(i);

        repeat (3) @(posedge clk);
        #1;
        check(!grant_vld && !grant_fail && !dup_err, "R10 in reset",
              $sformatf("%0b%0b%0b", grant_vld, grant_fail, dup_err), "000");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check(!grant_vld && !grant_fail && !dup_err, "R10 after reset",
              $sformatf("%0b%0b%0b", grant_vld, grant_fail, dup_err), "000");
        running = 1;

        // R1 R2: boot order, reserved slot skipped
        for (int i = 0; i < NS - 1; i++) step(1, 0, 0, "R1 boot order");
        // R4: empty pool
        step(1, 0, 0, "R4 empty");
        step(0, 0, 0, "idle");
        // R6: releasing reserved slot does nothing
        step(0, 1, RESV, "R6");
        step(1, 0, 0, "R6 pool still empty");
        // R5: tail append order
        step(0, 1, 6, "R5");
        step(0, 1, 2, "R5");
        step(0, 1, 0, "R5");
        step(1, 0, 0, "R5 fifo order");
        step(1, 0, 0, "R5 fifo order");
        step(1, 0, 0, "R5 fifo order");
        // R8: simultaneous on empty
        step(1, 1, 3, "R8 fail on empty");
        step(1, 0, 0, "R8 released slot granted");
        // R9: simultaneous on non-empty
        step(0, 1, 1, "R9");
        step(0, 1, 5, "R9");
        step(1, 1, 7, "R9 head granted");
        step(1, 0, 0, "R9 order");
        step(1, 0, 0, "R9 released behind");
        // R7: duplicate release
        step(0, 1, 2, "R7");
        step(0, 1, 2, "R7 duplicate");
        step(0, 0, 0, "R7 sticky");
        step(1, 0, 0, "R7 one copy");
        step(1, 0, 0, "R7 no second copy");
        // Mixed traffic
        lfsr = 8'hA5;
        for (int k = 0; k < 400; k++) begin
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            step(lfsr[0], lfsr[1] | lfsr[6], int'(lfsr[4:2]), "R5 R9 mixed");
        end
        step(0, 0, 0, "drain");
        step(0, 0, 0, "drain");
        @(posedge clk);
        #2;
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule